// File: doc/BRIEF.md
# Downstream Port Power and Overcurrent Supervisor

This block controls the power enables of a hub's downstream ports and watches the fault signals that the external power switches return. Each port has one active-low enable output and one active-low fault input. A fault input passes through a two-stage synchronizer and then a per-port debounce filter that counts millisecond ticks. The time a fault must persist before it is believed and the time a clean input must persist before the fault is released are set separately, each as a 4-bit millisecond count.

A request decoder elsewhere in the hub sends one-cycle set-power, clear-power and clear-change pulses for each port. It also holds the mode bits. In individual mode each port switches on its own. In ganged mode a command to any port switches all active ports together. Reporting is either per port or global. In global reporting every active port shows the combined fault state. A confirmed fault removes power from the faulty port, or from every port in ganged mode, and latches a change flag that stays set until it is cleared explicitly. A port-active mask removes unused ports from both the power and the fault paths. All pins are plain level or pulse control and status. No streaming data passes through the block, so there is no valid/ready handshake.

Top module: `hub_port_power`

## Requirements
- R1: After reset every `pwr_n` bit is 1 (all ports unpowered), and `oc_status` and `oc_change` are all 0.
- R2: With `gang_mode`=0, a `set_pwr[i]` pulse drives `pwr_n[i]` low one cycle later and a `clr_pwr[i]` pulse drives it high. If both arrive for the same port in the same cycle, clear wins.
- R3: With `gang_mode`=1, a set or clear pulse on any active port applies to every active port.
- R4: `oc_status[i]` rises only after `oc_n[i]` has been low, past the synchronizer, for `t_oc_on` consecutive `ms_tick` pulses. A value of 0 behaves as 1.
- R5: A confirmed fault is released only after the input has been high for `t_oc_off` consecutive ticks. Any return to low restarts that count.
- R6: On the rise of a reported fault, power is removed on the next cycle. In individual mode this applies to that port. In ganged mode it applies to every port.
- R7: `oc_change[i]` is set when `oc_status[i]` rises. It stays set until a `clr_chg[i]` pulse arrives. A rise in the same cycle as the clear wins.
- R8: A set-power pulse is ignored while the port reports a fault. In ganged mode it is ignored while any port reports a fault.
- R9: With `rpt_global`=1, every active port reports the OR of the filtered faults of all active ports.
- R10: With `oc_detect_en`=0, all filters are held cleared and `oc_status` reads 0.
- R11: A port with `port_active[i]`=0 never drives power (`pwr_n[i]`=1). Its fault input is ignored and its status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| gang_mode | input | 1 | 1 = ganged switching, 0 = individual (default) |
| rpt_global | input | 1 | 1 = global fault reporting, 0 = per port |
| oc_detect_en | input | 1 | Enables fault detection |
| port_active | input | NPORTS | Usable-port mask |
| t_oc_on | input | TW | Fault assert filter time in ticks |
| t_oc_off | input | TW | Fault release filter time in ticks |
| set_pwr | input | NPORTS | Per-port power-on command pulses |
| clr_pwr | input | NPORTS | Per-port power-off command pulses |
| clr_chg | input | NPORTS | Per-port change-flag clear pulses |
| oc_n | input | NPORTS | Active-low fault inputs from power switches |
| pwr_n | output | NPORTS | Active-low port power enables |
| oc_status | output | NPORTS | Reported filtered fault per port |
| oc_change | output | NPORTS | Sticky fault change flags |

## Verification
The debounce filter is tried with three fault input patterns. A low held one tick short of the assert time tells whether the filter confirms early. A full-length low confirms the fault and triggers power removal. A release interrupted by a brief low tells a filter that restarts its count from one that only counts total high time. The same fault is then run through individual, ganged and global-reporting modes, which shows whether a fault shuts down only its own port or all ports, and whether it shows on one status bit or on all of them. Further runs with a masked port and with detection disabled confirm that those inputs leave the outputs untouched.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  typedef enum logic {SW_INDIV = 1'b0, SW_GANGED = 1'b1} sw_mode_e;
  typedef enum logic {RPT_PORT = 1'b0, RPT_GLOBAL = 1'b1} rpt_mode_e;
endpackage

// File: rtl/hpp_oc_filter.sv
module hpp_oc_filter #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          oc_n_i,
  input  logic [TW-1:0] t_on_i,
  input  logic [TW-1:0] t_off_i,
  output logic          oc_o
);
  localparam int CW = TW + 1;

  logic [1:0]    sync_q;
  logic          raw;
  logic          state_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] lim_sel;
  logic [CW-1:0] lim_eff;
  logic [CW-1:0] cnt_nxt;

  assign raw     = sync_q[1];
  assign lim_sel = state_q ? t_off_i : t_on_i;
  assign lim_eff = (lim_sel == '0) ? CW'(1) : {1'b0, lim_sel};
  assign cnt_nxt = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], ~oc_n_i};
      if (!en_i) begin
        state_q <= 1'b0;
        cnt_q   <= '0;
      end else if (raw == state_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_nxt >= lim_eff) begin
          state_q <= ~state_q;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  assign oc_o = state_q;

  // R4
  filt_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && en_i) |=> (state_q == $past(state_q)) || !en_i);

  // R10
  filt_disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !state_q);
endmodule

// File: rtl/hpp_oc_report.sv
module hpp_oc_report #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              global_i,
  input  logic [NPORTS-1:0] active_i,
  input  logic [NPORTS-1:0] filt_i,
  input  logic [NPORTS-1:0] clr_chg_i,
  output logic [NPORTS-1:0] rep_o,
  output logic [NPORTS-1:0] rise_o,
  output logic [NPORTS-1:0] chg_o
);
  import hpp_pkg::*;

  logic [NPORTS-1:0] filt_act;
  logic              any_oc;
  logic [NPORTS-1:0] rep_q;
  rpt_mode_e         mode;

  assign mode     = rpt_mode_e'(global_i);
  assign filt_act = filt_i & active_i;
  assign any_oc   = |filt_act;
  assign rep_o    = (mode == RPT_GLOBAL) ? ({NPORTS{any_oc}} & active_i) : filt_act;
  assign rise_o   = rep_o & ~rep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_q <= '0;
      chg_o <= '0;
    end else begin
      rep_q <= rep_o;
      chg_o <= (chg_o & ~clr_chg_i) | rise_o;
    end
  end

  generate
    for (genvar i = 0; i < NPORTS; i++) begin : g_chk
      // R7
      chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_o[i] && !clr_chg_i[i]) |=> chg_o[i]);
      // R7
      chg_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[i] |=> chg_o[i]);
      // R11
      inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i[i] |-> !rep_o[i]);
    end
  endgenerate
endmodule

// File: rtl/hpp_port_switch.sv
module hpp_port_switch #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gang_i,
  input  logic [NPORTS-1:0] active_i,
  input  logic [NPORTS-1:0] set_i,
  input  logic [NPORTS-1:0] clr_i,
  input  logic [NPORTS-1:0] rep_i,
  input  logic [NPORTS-1:0] rise_i,
  output logic [NPORTS-1:0] pwr_on_o
);
  import hpp_pkg::*;

  sw_mode_e          mode;
  logic              any_set;
  logic              any_clr;
  logic              any_rise;
  logic              any_rep;
  logic [NPORTS-1:0] pwr_nxt;

  assign mode     = sw_mode_e'(gang_i);
  assign any_set  = |(set_i & active_i);
  assign any_clr  = |(clr_i & active_i);
  assign any_rise = |rise_i;
  assign any_rep  = |rep_i;

  generate
    for (genvar i = 0; i < NPORTS; i++) begin : g_port
      always_comb begin
        pwr_nxt[i] = pwr_on_o[i];
        if (!active_i[i]) begin
          pwr_nxt[i] = 1'b0;
        end else if (mode == SW_GANGED) begin
          if (any_rise || any_clr)      pwr_nxt[i] = 1'b0;
          else if (any_set && !any_rep) pwr_nxt[i] = 1'b1;
        end else begin
          if (rise_i[i] || clr_i[i])       pwr_nxt[i] = 1'b0;
          else if (set_i[i] && !rep_i[i])  pwr_nxt[i] = 1'b1;
        end
      end

      // R11
      inactive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i[i] |=> !pwr_on_o[i]);
      // R6
      fault_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i[i] |=> !pwr_on_o[i]);
      // R8
      set_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_i[i] && !pwr_on_o[i]) |=> !pwr_on_o[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pwr_on_o <= '0;
    else        pwr_on_o <= pwr_nxt;
  end
endmodule

// File: rtl/hub_port_power.sv
module hub_port_power #(
  parameter int NPORTS = 4,
  parameter int TW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              gang_mode,
  input  logic              rpt_global,
  input  logic              oc_detect_en,
  input  logic [NPORTS-1:0] port_active,
  input  logic [TW-1:0]     t_oc_on,
  input  logic [TW-1:0]     t_oc_off,
  input  logic [NPORTS-1:0] set_pwr,
  input  logic [NPORTS-1:0] clr_pwr,
  input  logic [NPORTS-1:0] clr_chg,
  input  logic [NPORTS-1:0] oc_n,
  output logic [NPORTS-1:0] pwr_n,
  output logic [NPORTS-1:0] oc_status,
  output logic [NPORTS-1:0] oc_change
);
  logic [NPORTS-1:0] filt;
  logic [NPORTS-1:0] rise;
  logic [NPORTS-1:0] pwr_on;

  generate
    for (genvar i = 0; i < NPORTS; i++) begin : g_filt
      hpp_oc_filter #(.TW(TW)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (ms_tick),
        .en_i    (oc_detect_en && port_active[i]),
        .oc_n_i  (oc_n[i]),
        .t_on_i  (t_oc_on),
        .t_off_i (t_oc_off),
        .oc_o    (filt[i])
      );
    end
  endgenerate

  hpp_oc_report #(.NPORTS(NPORTS)) u_rep (
    .clk       (clk),
    .rst_n     (rst_n),
    .global_i  (rpt_global),
    .active_i  (port_active),
    .filt_i    (filt),
    .clr_chg_i (clr_chg),
    .rep_o     (oc_status),
    .rise_o    (rise),
    .chg_o     (oc_change)
  );

  hpp_port_switch #(.NPORTS(NPORTS)) u_sw (
    .clk      (clk),
    .rst_n    (rst_n),
    .gang_i   (gang_mode),
    .active_i (port_active),
    .set_i    (set_pwr),
    .clr_i    (clr_pwr),
    .rep_i    (oc_status),
    .rise_i   (rise),
    .pwr_on_o (pwr_on)
  );

  assign pwr_n = ~pwr_on;

  // R1
  reset_unpowered_chk: assert property (@(posedge clk)
    !rst_n |=> (pwr_n == '1) && (oc_change == '0));
endmodule

// File: tb/hub_port_power_tb_top.sv
module hub_port_power_tb_top;
  localparam int N = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic ms_tick = 0;
  logic gang_mode = 0, rpt_global = 0, oc_detect_en = 1;
  logic [N-1:0] port_active = '1;
  logic [3:0] t_oc_on = 4'd3, t_oc_off = 4'd2;
  logic [N-1:0] set_pwr = '0, clr_pwr = '0, clr_chg = '0;
  logic [N-1:0] oc_n = '1;
  logic [N-1:0] pwr_n, oc_status, oc_change;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    string    req;
    logic [N-1:0] p, o, c;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  hub_port_power #(.NPORTS(N), .TW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .gang_mode(gang_mode),
    .rpt_global(rpt_global), .oc_detect_en(oc_detect_en), .port_active(port_active),
    .t_oc_on(t_oc_on), .t_oc_off(t_oc_off), .set_pwr(set_pwr), .clr_pwr(clr_pwr),
    .clr_chg(clr_chg), .oc_n(oc_n), .pwr_n(pwr_n), .oc_status(oc_status),
    .oc_change(oc_change)
  );

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (pwr_n !== e.p || oc_status !== e.o || oc_change !== e.c) begin
          n_fail++;
          $display("FAIL %s: pwr_n=%b oc_status=%b oc_change=%b expected %b %b %b",
                   e.req, pwr_n, oc_status, oc_change, e.p, e.o, e.c);
        end
      end
    end
  end

  task automatic expect_state(input string req, input logic [N-1:0] p, o, c);
    @(posedge clk); #2;
    q.push_back('{req, p, o, c});
    @(negedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1 ms_tick = 1;
      @(posedge clk); #1 ms_tick = 0;
    end
  endtask

  task automatic drive_oc(input logic [N-1:0] v);
    @(posedge clk); #1 oc_n = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [N-1:0] s, input logic [N-1:0] c, input logic [N-1:0] k);
    @(posedge clk); #1 set_pwr = s; clr_pwr = c; clr_chg = k;
    @(posedge clk); #1 set_pwr = '0; clr_pwr = '0; clr_chg = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_state("R1 reset", 4'b1111, 4'b0000, 4'b0000);

    cmd(4'b0101, 4'b0000, 4'b0000);
    expect_state("R2 set ports 0,2", 4'b1010, 4'b0000, 4'b0000);
    cmd(4'b0000, 4'b0100, 4'b0000);
    expect_state("R2 clear port 2", 4'b1110, 4'b0000, 4'b0000);
    cmd(4'b0010, 4'b0010, 4'b0000);
    expect_state("R2 clear wins over set", 4'b1110, 4'b0000, 4'b0000);

    drive_oc(4'b1110);
    ticks(2);
    expect_state("R4 short low not confirmed", 4'b1110, 4'b0000, 4'b0000);
    ticks(1);
    expect_state("R4 R6 R7 fault confirmed, port0 off", 4'b1111, 4'b0001, 4'b0001);
    cmd(4'b0001, 4'b0000, 4'b0000);
    expect_state("R8 set ignored during fault", 4'b1111, 4'b0001, 4'b0001);

    drive_oc(4'b1111);
    ticks(1);
    expect_state("R5 release not yet", 4'b1111, 4'b0001, 4'b0001);
    drive_oc(4'b1110);
    drive_oc(4'b1111);
    ticks(1);
    expect_state("R5 glitch restarts release count", 4'b1111, 4'b0001, 4'b0001);
    ticks(1);
    expect_state("R5 R7 released, flag sticky", 4'b1111, 4'b0000, 4'b0001);
    cmd(4'b0000, 4'b0000, 4'b0001);
    expect_state("R7 flag cleared", 4'b1111, 4'b0000, 4'b0000);

    gang_mode = 1; t_oc_on = 4'd0;
    cmd(4'b0010, 4'b0000, 4'b0000);
    expect_state("R3 ganged set powers all", 4'b0000, 4'b0000, 4'b0000);
    drive_oc(4'b0111);
    ticks(1);
    expect_state("R4 R6 zero time acts as one, ganged cut", 4'b1111, 4'b1000, 4'b1000);

    rpt_global = 1;
    expect_state("R9 global reporting", 4'b1111, 4'b1111, 4'b1111);
    cmd(4'b0001, 4'b0000, 4'b0000);
    expect_state("R8 ganged set ignored during fault", 4'b1111, 4'b1111, 4'b1111);

    oc_detect_en = 0;
    expect_state("R10 detection disabled", 4'b1111, 4'b0000, 4'b1111);
    cmd(4'b0000, 4'b0000, 4'b1111);
    expect_state("R7 clear all flags", 4'b1111, 4'b0000, 4'b0000);

    port_active = 4'b0111; gang_mode = 0; rpt_global = 0; t_oc_on = 4'd1;
    @(posedge clk); #1 oc_detect_en = 1;
    ticks(3);
    expect_state("R11 masked fault ignored", 4'b1111, 4'b0000, 4'b0000);
    cmd(4'b1111, 4'b0000, 4'b0000);
    expect_state("R11 masked port unpowered", 4'b1000, 4'b0000, 4'b0000);
    gang_mode = 1;
    cmd(4'b0000, 4'b0001, 4'b0000);
    expect_state("R3 ganged clear removes all", 4'b1111, 4'b0000, 4'b0000);

    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule